// File: doc/BRIEF.md
# Coding Violation Line Quality Monitor

This block turns a stream of coding-violation pulses from a line decoder into a coarse verdict on line quality. It counts violations over a fixed measurement window and compares the total against a limit. The limit corresponds to an error ratio of about one in a million at the selected line rate. At every window boundary the verdict is latched onto an active-high `poor_quality` output, and that output then holds its value until the next boundary.

The window is built from a slow timebase that arrives as single-cycle `tick` strobes in the core clock domain. At the 34 Mbit/s rate the window is `TICKS_34` ticks long and the limit is `LIMIT_34` violations (10 ticks and 344 by default). At the 8 Mbit/s rate the window is `TICKS_8` ticks long and the limit is `LIMIT_8` violations (40 ticks and 338 by default). The verdict has meaning only while ticks are supplied. In rail (codec bypass) mode the verdict has no meaning, so the output is forced low and the measurement is held cleared.

Top module: `lq_monitor`

## Requirements
- R1: After reset `poor_quality` is 0, and both the tick count and the violation count start from zero.
- R2: A window closes on the tick that completes `TICKS_34` ticks when `rate_sel` is 0, or `TICKS_8` ticks when `rate_sel` is 1. Ticks before that leave the output unchanged.
- R3: If the number of violations in a closed window is greater than the rate's limit, `poor_quality` is 1 in the cycle after the clock edge that takes the closing tick.
- R4: If the number of violations in a closed window is less than or equal to the rate's limit, `poor_quality` is 0 from that same cycle. A count exactly at the limit gives 0.
- R5: The limit is `LIMIT_34` when `rate_sel` is 0 and `LIMIT_8` when `rate_sel` is 1. The value of `rate_sel` on the closing tick selects it.
- R6: Between window boundaries `poor_quality` does not change, whatever violations arrive.
- R7: A violation pulse that is high in the same cycle as the closing tick is counted in the new window and not in the window that is closing.
- R8: The violation count saturates at its all-ones value and never wraps. A window far above the limit therefore still gives 1.
- R9: While `rail_mode` is 1, `poor_quality` is 0 and the tick and violation counts are held at zero. After `rail_mode` returns to 0, a fresh window starts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cv_pulse | input | 1 | One-cycle strobe per detected coding violation |
| tick | input | 1 | One-cycle strobe from the measurement timebase |
| rate_sel | input | 1 | 0 = 34 Mbit/s window and limit, 1 = 8 Mbit/s window and limit |
| rail_mode | input | 1 | 1 = codec bypassed; verdict forced low and measurement cleared |
| poor_quality | output | 1 | 1 = last closed window exceeded the violation limit |

## Verification
The embedded assertions check several properties on every clock. The tick counter returns to zero after each window boundary. The violation counter restarts at each boundary, stays put once saturated, and is held at zero in rail mode. The latched verdict never moves except at a boundary. The assertions cannot show that the verdict is correct for a given count. Only the bench scenarios can show that: counts just below, exactly at and just above each rate's limit, a violation that lands on the closing tick, a count big enough to wrap an unsaturated counter, windows of the wrong length for the selected rate, and a rail-mode episode with violations that must leave no trace.

// File: rtl/lq_pkg.sv
package lq_pkg;
  typedef enum logic {
    RATE_34M = 1'b0,
    RATE_8M  = 1'b1
  } lq_rate_e;

  function automatic int unsigned lq_max(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/lq_window_timer.sv
module lq_window_timer #(
  parameter int unsigned TICKS_A = 10,
  parameter int unsigned TICKS_B = 40,
  parameter int unsigned TW      = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  input  logic rate_sel,
  output logic win_end
);
  import lq_pkg::*;

  localparam logic [TW-1:0] TERM_A = TW'(TICKS_A - 1);
  localparam logic [TW-1:0] TERM_B = TW'(TICKS_B - 1);

  logic [TW-1:0] tc_q, tc_d, term;
  logic          tc_en;

  always_comb begin
    term    = (lq_rate_e'(rate_sel) == RATE_8M) ? TERM_B : TERM_A;
    win_end = tick & ~clr & (tc_q >= term);
    tc_en   = clr | tick;
    if (clr || win_end) tc_d = '0;
    else                tc_d = tc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     tc_q <= '0;
    else if (tc_en) tc_q <= tc_d;
  end

  assert_window_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    win_end |=> (tc_q == '0));

  assert_rail_timer_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (tc_q == '0));
endmodule

// File: rtl/lq_cv_counter.sv
module lq_cv_counter #(
  parameter int unsigned CW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          win_end,
  input  logic          cv_pulse,
  output logic [CW-1:0] cv_count
);
  localparam logic [CW-1:0] SAT = '1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = clr | win_end | (cv_pulse & (cnt_q != SAT));
    if (clr)          cnt_d = '0;
    else if (win_end) cnt_d = CW'(cv_pulse);
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cv_count = cnt_q;

  assert_no_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !win_end && cnt_q == SAT) |=> (cnt_q == SAT));

  assert_restart_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (win_end && !clr && !cv_pulse) |=> (cnt_q == '0));

  assert_restart_carry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (win_end && !clr && cv_pulse) |=> (cnt_q == CW'(1)));
endmodule

// File: rtl/lq_verdict.sv
module lq_verdict #(
  parameter int unsigned CW      = 9,
  parameter int unsigned LIMIT_A = 344,
  parameter int unsigned LIMIT_B = 338
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          win_end,
  input  logic          rate_sel,
  input  logic [CW-1:0] cv_count,
  output logic          verdict
);
  import lq_pkg::*;

  localparam logic [CW-1:0] LIM_A = CW'(LIMIT_A);
  localparam logic [CW-1:0] LIM_B = CW'(LIMIT_B);

  logic [CW-1:0] limit;
  logic          v_q, v_d, v_en;

  always_comb begin
    limit = (lq_rate_e'(rate_sel) == RATE_8M) ? LIM_B : LIM_A;
    v_en  = clr | win_end;
    v_d   = ~clr & (cv_count > limit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    v_q <= 1'b0;
    else if (v_en) v_q <= v_d;
  end

  assign verdict = v_q;

  assert_hold_between_windows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_end && !clr) |=> $stable(v_q));
endmodule

// File: rtl/lq_monitor.sv
module lq_monitor #(
  parameter int unsigned TICKS_34 = 10,
  parameter int unsigned TICKS_8  = 40,
  parameter int unsigned LIMIT_34 = 344,
  parameter int unsigned LIMIT_8  = 338
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cv_pulse,
  input  logic tick,
  input  logic rate_sel,
  input  logic rail_mode,
  output logic poor_quality
);
  import lq_pkg::*;

  localparam int unsigned MAX_TICKS = lq_max(TICKS_34, TICKS_8);
  localparam int unsigned MAX_LIMIT = lq_max(LIMIT_34, LIMIT_8);
  localparam int unsigned TW        = (MAX_TICKS < 2) ? 1 : $clog2(MAX_TICKS + 1);
  localparam int unsigned CW        = $clog2(MAX_LIMIT + 2);

  logic [1:0]    rst_sync_q;
  logic          rst_core_n;
  logic          win_end;
  logic [CW-1:0] cv_count;
  logic          verdict;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  lq_window_timer #(.TICKS_A(TICKS_34), .TICKS_B(TICKS_8), .TW(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .clr      (rail_mode),
    .tick     (tick),
    .rate_sel (rate_sel),
    .win_end  (win_end)
  );

  lq_cv_counter #(.CW(CW)) u_count (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .clr      (rail_mode),
    .win_end  (win_end),
    .cv_pulse (cv_pulse),
    .cv_count (cv_count)
  );

  lq_verdict #(.CW(CW), .LIMIT_A(LIMIT_34), .LIMIT_B(LIMIT_8)) u_verdict (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .clr      (rail_mode),
    .win_end  (win_end),
    .rate_sel (rate_sel),
    .cv_count (cv_count),
    .verdict  (verdict)
  );

  assign poor_quality = verdict & ~rail_mode;

  assert_rail_count_clear_R9: assert property (@(posedge clk) disable iff (!rst_core_n)
    rail_mode |=> (cv_count == '0 && !verdict));

  assert_reset_state_R1: assert property (@(posedge clk)
    (!rst_core_n) |-> (!poor_quality && cv_count == '0));
endmodule

// File: tb/lq_monitor_test.sv
module lq_monitor_test;
  localparam int T34 = 3;
  localparam int T8  = 5;
  localparam int L34 = 344;
  localparam int L8  = 338;

  // vector: [12] expected, [11] rate, [10] coincident violation, [9:0] violation count
  localparam int NV = 10;
  localparam logic [12:0] VEC [NV] = '{
    {1'b0, 1'b0, 1'b0, 10'd343},
    {1'b0, 1'b0, 1'b0, 10'd344},
    {1'b1, 1'b0, 1'b0, 10'd345},
    {1'b0, 1'b0, 1'b1, 10'd344},
    {1'b1, 1'b0, 1'b0, 10'd344},
    {1'b0, 1'b1, 1'b0, 10'd338},
    {1'b1, 1'b1, 1'b0, 10'd339},
    {1'b0, 1'b1, 1'b0, 10'd337},
    {1'b1, 1'b0, 1'b0, 10'd600},
    {1'b0, 1'b0, 1'b0, 10'd0}
  };

  logic clk = 1'b0;
  logic rst_n, cv_pulse, tick, rate_sel, rail_mode;
  logic poor_quality;
  int   n_chk  = 0;
  int   n_fail = 0;
  bit   done   = 1'b0;

  always #2 clk = ~clk;

  lq_monitor #(.TICKS_34(T34), .TICKS_8(T8), .LIMIT_34(L34), .LIMIT_8(L8)) uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .cv_pulse     (cv_pulse),
    .tick         (tick),
    .rate_sel     (rate_sel),
    .rail_mode    (rail_mode),
    .poor_quality (poor_quality)
  );

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input logic got, input logic exp, input string req, input string what);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: poor_quality=%b expected %b", req, what, got, exp);
    end
  endtask

  task automatic violations(input int n);
    for (int i = 0; i < n; i++) begin
      cv_pulse = 1'b1; cyc();
    end
    cv_pulse = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1; cyc();
      tick = 1'b0; cyc();
    end
  endtask

  task automatic close_window(input logic coinc);
    tick = 1'b1; cv_pulse = coinc; cyc();
    tick = 1'b0; cv_pulse = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cyc(); cyc();
    rst_n = 1'b1; cyc(); cyc(); cyc();
  endtask

  initial begin
    logic prev;
    cv_pulse = 0; tick = 0; rate_sel = 0; rail_mode = 0;
    do_reset();
    check(poor_quality, 1'b0, "R1", "after reset");

    // vector walk: R3, R4, R5, R6, R7, R8
    prev = 1'b0;
    for (int v = 0; v < NV; v++) begin
      int len;
      rate_sel = VEC[v][11];
      len = VEC[v][11] ? T8 : T34;
      violations(int'(VEC[v][9:0]));
      ticks(len - 1);
      check(poor_quality, prev, "R6", $sformatf("vector %0d before boundary", v));
      close_window(VEC[v][10]);
      check(poor_quality, VEC[v][12], (VEC[v][12] ? "R3/R5/R7/R8" : "R4/R5/R7"),
            $sformatf("vector %0d after boundary", v));
      prev = VEC[v][12];
    end

    // R2: window length follows rate_sel
    rate_sel = 0; violations(L34 + 1); ticks(T34 - 1); close_window(1'b0);
    check(poor_quality, 1'b1, "R3", "set high before length test");
    rate_sel = 1; ticks(T34);
    check(poor_quality, 1'b1, "R2", "8M window not closed after short tick count");
    ticks(T8 - T34 - 1); close_window(1'b0);
    check(poor_quality, 1'b0, "R2", "8M window closed after full tick count");

    // R9: rail mode forces low and clears measurement
    rate_sel = 0; violations(L34 + 5); ticks(T34 - 1); close_window(1'b0);
    check(poor_quality, 1'b1, "R3", "high before rail mode");
    violations(200); ticks(1);
    rail_mode = 1'b1; #1;
    check(poor_quality, 1'b0, "R9", "output low during rail mode");
    violations(400); ticks(T34 + 2);
    check(poor_quality, 1'b0, "R9", "still low in rail mode after windows");
    rail_mode = 1'b0; cyc();
    check(poor_quality, 1'b0, "R9", "low after leaving rail mode");
    violations(L34); ticks(T34 - 1);
    check(poor_quality, 1'b0, "R9", "no boundary before fresh window completes");
    close_window(1'b0);
    check(poor_quality, 1'b0, "R9", "fresh window holds only new violations");

    // R1: reset mid-run clears a high verdict
    violations(L34 + 1); ticks(T34 - 1); close_window(1'b0);
    check(poor_quality, 1'b1, "R3", "high before second reset");
    violations(L34); ticks(1);
    do_reset();
    check(poor_quality, 1'b0, "R1", "after mid-run reset");
    violations(L34); ticks(T34 - 1); close_window(1'b0);
    check(poor_quality, 1'b0, "R1", "counts cleared by reset");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule